// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block drives the clock-by-clock work a small processor core does when it takes an interrupt and when it leaves one. It accepts an interrupt request while the global enable is set and no sequence is running. If the current instruction has not finished, the block waits for that. It then runs a fixed four-cycle entry. In that entry it saves the 16-bit return address as two bytes on a byte-wide stack, clears the global enable, and gives the core the handler address. That address is the vector base plus the vector number.

If the core is asleep when the request is accepted, an external wake-up delay runs first, followed by a fixed four-cycle penalty. After that comes the same entry sequence. A return-from-interrupt strobe starts a four-cycle return. The return reads both bytes back through a stack port with one cycle of read latency, moves the stack pointer up by two, hands the restored address to the core and sets the global enable again. Instruction decode and execution belong to the surrounding core.

Top module: `isr_sequencer`

## Requirements
- R1: After a synchronous active-high reset: `busy` is 0, `gie` is 1, `sp` equals `SP_INIT`, and `mem_we`, `mem_re` and `pc_load` are 0.
- R2: A request is accepted in a cycle where `irq_req` is 1, `gie` is 1 and `busy` is 0. The handler address given on `pc_out` is `VEC_BASE + irq_vec` as sampled in that cycle.
- R3: When a request is accepted while awake, entry starts in the cycle after the first cycle in which `instr_done` is 1. That cycle may be the acceptance cycle itself. While waiting, `busy` is 1.
- R4: Entry lasts four cycles. `pc_load` is 1 for exactly the fourth cycle. Counting the cycle after the `instr_done` cycle as cycle 1, `pc_load` appears in cycle 4.
- R5: During the first two entry cycles, the low byte of the return address (`pc_in`, taken when entry starts) is written at address `sp`. The high byte is then written at `sp-1`. After the second entry cycle, `sp` has decreased by 2.
- R6: `gie` is 0 from the second entry cycle onward, so it is 0 when `pc_load` rises on entry.
- R7: If `sleeping` is 1 in the acceptance cycle, `instr_done` is not waited for. Entry starts after `wake_delay + 4` cycles, so `pc_load` comes `wake_delay + 8` cycles after the acceptance cycle.
- R8: `irq_req` and `reti_exec` have no effect while `busy` is 1. `irq_req` also has no effect while `gie` is 0. A request under either condition leaves `busy`, `sp` and the handler address unchanged.
- R9: `reti_exec` while idle, with no request accepted, starts a four-cycle return. In cycle 1 it reads `sp+1` and in cycle 2 it reads `sp+2`; the data returns one cycle after each read. `pc_load` is 1 in cycle 4, with `pc_out` equal to {byte from `sp+1`, byte from `sp+2`}.
- R10: After a return, `sp` has increased by 2 and `gie` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request |
| irq_vec | input | VEC_W | Vector number of the request |
| instr_done | input | 1 | Current instruction completes this cycle |
| sleeping | input | 1 | Core is in sleep mode |
| wake_delay | input | WD_W | Wake-up delay in cycles |
| reti_exec | input | 1 | Return-from-interrupt instruction strobe |
| pc_in | input | 16 | Return address to save |
| mem_we | output | 1 | Stack write enable |
| mem_re | output | 1 | Stack read enable |
| mem_addr | output | SP_W | Stack address |
| mem_wdata | output | 8 | Stack write byte |
| mem_rdata | input | 8 | Stack read byte, one cycle after `mem_re` |
| sp | output | SP_W | Stack pointer |
| gie | output | 1 | Global interrupt enable |
| pc_out | output | 16 | New program counter value |
| pc_load | output | 1 | Core loads `pc_out` this cycle |
| busy | output | 1 | A sequence is waiting or running |

## Verification
The assertions rely on the stack memory returning read data exactly one cycle after `mem_re`. They also rely on `pc_in` being stable from the acceptance cycle until entry starts. The bench models the memory with that registered read port and holds the return address constant for the whole entry. Each return is issued only after a completed entry, so the bytes it reads are a frame the block itself pushed. Requests and return strobes sent while `busy` or with `gie` clear are injected on purpose, and the later results are compared with the untouched expected frame.

// File: rtl/isr_seq_pkg.sv
package isr_seq_pkg;

    localparam int unsigned ENTRY_CYCLES  = 4;
    localparam int unsigned RETURN_CYCLES = 4;
    localparam int unsigned SLEEP_PENALTY = 4;
    localparam int unsigned STEP_W        = $clog2(ENTRY_CYCLES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DELAY,
        ST_ENTRY,
        ST_RET
    } seq_state_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } pc_bytes_t;

    function automatic logic [15:0] vector_target(input logic [15:0] base,
                                                  input logic [15:0] vnum);
        return base + vnum;
    endfunction

endpackage

// File: rtl/isr_seq_fsm.sv
module isr_seq_fsm
    import isr_seq_pkg::*;
#(
    parameter int unsigned WD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                irq_req,
    input  logic                gie,
    input  logic                reti_exec,
    input  logic                instr_done,
    input  logic                sleeping,
    input  logic [WD_W-1:0]     wake_delay,
    output seq_state_e          state,
    output logic [STEP_W-1:0]   step,
    output logic                accept,
    output logic                entry_start,
    output logic                busy
);
    localparam int unsigned CNT_W = WD_W + 1;
    localparam logic [STEP_W-1:0] LAST_ENTRY = STEP_W'(ENTRY_CYCLES - 1);
    localparam logic [STEP_W-1:0] LAST_RET   = STEP_W'(RETURN_CYCLES - 1);

    seq_state_e          state_nxt;
    logic [STEP_W-1:0]   step_nxt;
    logic [CNT_W-1:0]    cnt, cnt_nxt;

    always_comb begin
        state_nxt   = state;
        step_nxt    = step;
        cnt_nxt     = cnt;
        accept      = 1'b0;
        entry_start = 1'b0;
        unique case (state)
            ST_IDLE: begin
                step_nxt = '0;
                if (irq_req && gie) begin
                    accept = 1'b1;
                    if (sleeping) begin
                        state_nxt = ST_DELAY;
                        cnt_nxt   = CNT_W'(wake_delay) + CNT_W'(SLEEP_PENALTY);
                    end else if (instr_done) begin
                        state_nxt   = ST_ENTRY;
                        entry_start = 1'b1;
                    end else begin
                        state_nxt = ST_WAIT;
                    end
                end else if (reti_exec) begin
                    state_nxt = ST_RET;
                end
            end
            ST_WAIT: begin
                if (instr_done) begin
                    state_nxt   = ST_ENTRY;
                    step_nxt    = '0;
                    entry_start = 1'b1;
                end
            end
            ST_DELAY: begin
                if (cnt <= CNT_W'(1)) begin
                    state_nxt   = ST_ENTRY;
                    step_nxt    = '0;
                    entry_start = 1'b1;
                end else begin
                    cnt_nxt = cnt - CNT_W'(1);
                end
            end
            ST_ENTRY: begin
                if (step == LAST_ENTRY) begin
                    state_nxt = ST_IDLE;
                    step_nxt  = '0;
                end else begin
                    step_nxt = step + STEP_W'(1);
                end
            end
            ST_RET: begin
                if (step == LAST_RET) begin
                    state_nxt = ST_IDLE;
                    step_nxt  = '0;
                end else begin
                    step_nxt = step + STEP_W'(1);
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= '0;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            step  <= step_nxt;
            cnt   <= cnt_nxt;
        end
    end

    assign busy = (state != ST_IDLE);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) && !instr_done |=> (state == ST_WAIT));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        busy && irq_req |-> !accept);

    // R7
    delay_no_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DELAY) |=> (state == ST_DELAY) || (state == ST_ENTRY));

endmodule

// File: rtl/isr_seq_ctx.sv
module isr_seq_ctx
    import isr_seq_pkg::*;
#(
    parameter int unsigned   VEC_W    = 5,
    parameter int unsigned   SP_W     = 8,
    parameter logic [15:0]   VEC_BASE = 16'h0040,
    parameter logic [SP_W-1:0] SP_INIT = '1
) (
    input  logic                clk,
    input  logic                rst,
    input  seq_state_e          state,
    input  logic [STEP_W-1:0]   step,
    input  logic                accept,
    input  logic                entry_start,
    input  logic [VEC_W-1:0]    irq_vec,
    input  logic [15:0]         pc_in,
    input  logic [7:0]          mem_rdata,
    output logic                mem_we,
    output logic                mem_re,
    output logic [SP_W-1:0]     mem_addr,
    output logic [7:0]          mem_wdata,
    output logic [SP_W-1:0]     sp,
    output logic                gie,
    output logic [15:0]         pc_out,
    output logic                pc_load
);
    localparam logic [SP_W-1:0]   FRAME    = SP_W'(2);
    localparam logic [STEP_W-1:0] ST_FIRST = STEP_W'(0);
    localparam logic [STEP_W-1:0] ST_SECND = STEP_W'(1);
    localparam logic [STEP_W-1:0] ST_THIRD = STEP_W'(2);
    localparam logic [STEP_W-1:0] ST_LAST  = STEP_W'(ENTRY_CYCLES - 1);

    logic        entering, returning, ret_last;
    pc_bytes_t   ret_pc;
    pc_bytes_t   popped;
    logic [15:0] target;

    assign entering  = (state == ST_ENTRY);
    assign returning = (state == ST_RET);
    assign ret_last  = returning && (step == ST_LAST);

    always_comb begin
        mem_we    = entering  && (step == ST_FIRST || step == ST_SECND);
        mem_re    = returning && (step == ST_FIRST || step == ST_SECND);
        mem_wdata = (step == ST_FIRST) ? ret_pc.lo : ret_pc.hi;
        if (entering)
            mem_addr = (step == ST_FIRST) ? sp : sp - SP_W'(1);
        else if (returning)
            mem_addr = (step == ST_FIRST) ? sp + SP_W'(1) : sp + FRAME;
        else
            mem_addr = sp;
        pc_load = (entering || returning) && (step == ST_LAST);
        pc_out  = returning ? popped : target;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp     <= SP_INIT;
            gie    <= 1'b1;
            ret_pc <= '0;
            popped <= '0;
            target <= '0;
        end else begin
            if (accept)
                target <= vector_target(VEC_BASE, 16'(irq_vec));
            if (entry_start)
                ret_pc <= pc_in;
            if (entering && step == ST_FIRST)
                gie <= 1'b0;
            if (entering && step == ST_SECND)
                sp <= sp - FRAME;
            if (returning && step == ST_SECND)
                popped.hi <= mem_rdata;
            if (returning && step == ST_THIRD) begin
                popped.lo <= mem_rdata;
                sp        <= sp + FRAME;
            end
            if (ret_last)
                gie <= 1'b1;
        end
    end

    // R5
    sp_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sp) |-> (sp == $past(sp) - FRAME) || (sp == $past(sp) + FRAME));

    // R6
    gie_entry_chk: assert property (@(posedge clk) disable iff (rst)
        entering && pc_load |-> !gie);

    // R10
    gie_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gie) |-> $past(ret_last));

    // R4
    pc_load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !pc_load);

endmodule

// File: rtl/isr_sequencer.sv
module isr_sequencer
    import isr_seq_pkg::*;
#(
    parameter int unsigned     VEC_W    = 5,
    parameter int unsigned     WD_W     = 8,
    parameter int unsigned     SP_W     = 8,
    parameter logic [15:0]     VEC_BASE = 16'h0040,
    parameter logic [SP_W-1:0] SP_INIT  = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               irq_req,
    input  logic [VEC_W-1:0]   irq_vec,
    input  logic               instr_done,
    input  logic               sleeping,
    input  logic [WD_W-1:0]    wake_delay,
    input  logic               reti_exec,
    input  logic [15:0]        pc_in,
    output logic               mem_we,
    output logic               mem_re,
    output logic [SP_W-1:0]    mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    output logic [SP_W-1:0]    sp,
    output logic               gie,
    output logic [15:0]        pc_out,
    output logic               pc_load,
    output logic               busy
);
    seq_state_e         state;
    logic [STEP_W-1:0]  step;
    logic               accept;
    logic               entry_start;

    isr_seq_fsm #(.WD_W(WD_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .irq_req     (irq_req),
        .gie         (gie),
        .reti_exec   (reti_exec),
        .instr_done  (instr_done),
        .sleeping    (sleeping),
        .wake_delay  (wake_delay),
        .state       (state),
        .step        (step),
        .accept      (accept),
        .entry_start (entry_start),
        .busy        (busy)
    );

    isr_seq_ctx #(
        .VEC_W    (VEC_W),
        .SP_W     (SP_W),
        .VEC_BASE (VEC_BASE),
        .SP_INIT  (SP_INIT)
    ) u_ctx (
        .clk         (clk),
        .rst         (rst),
        .state       (state),
        .step        (step),
        .accept      (accept),
        .entry_start (entry_start),
        .irq_vec     (irq_vec),
        .pc_in       (pc_in),
        .mem_rdata   (mem_rdata),
        .mem_we      (mem_we),
        .mem_re      (mem_re),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .sp          (sp),
        .gie         (gie),
        .pc_out      (pc_out),
        .pc_load     (pc_load)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_we && !mem_re && !pc_load);

endmodule

// File: tb/test_isr_sequencer.sv
module test_isr_sequencer;
    localparam int unsigned VEC_W    = 5;
    localparam int unsigned WD_W     = 8;
    localparam int unsigned SP_W     = 8;
    localparam logic [15:0] VEC_BASE = 16'h0040;
    localparam logic [7:0]  SP_INIT  = 8'hFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_req = 1'b0;
    logic [VEC_W-1:0] irq_vec = '0;
    logic instr_done = 1'b0;
    logic sleeping = 1'b0;
    logic [WD_W-1:0] wake_delay = '0;
    logic reti_exec = 1'b0;
    logic [15:0] pc_in = '0;
    logic mem_we, mem_re, gie, pc_load, busy;
    logic [SP_W-1:0] mem_addr, sp;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = '0;
    logic [15:0] pc_out;

    logic [7:0] stack_mem [0:(1<<SP_W)-1];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    isr_sequencer #(
        .VEC_W(VEC_W), .WD_W(WD_W), .SP_W(SP_W),
        .VEC_BASE(VEC_BASE), .SP_INIT(SP_INIT)
    ) i_isr_sequencer (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec),
        .instr_done(instr_done), .sleeping(sleeping), .wake_delay(wake_delay),
        .reti_exec(reti_exec), .pc_in(pc_in), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .sp(sp), .gie(gie), .pc_out(pc_out), .pc_load(pc_load), .busy(busy)
    );

    always @(posedge clk) begin
        if (mem_we) stack_mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= stack_mem[mem_addr];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int entry_latency(input bit slp, input int d, input int wk);
        return slp ? wk + 8 : d + 4;
    endfunction

    task automatic run_entry(input logic [VEC_W-1:0] v, input int d, input bit slp,
                             input int wk, input logic [15:0] pcv);
        logic [SP_W-1:0] sp0;
        int n, n_load;
        bit got, gie_at;
        logic [15:0] pco;
        sp0 = sp;
        n_load = -1; got = 0; gie_at = 1; pco = '0;
        irq_req = 1'b1; irq_vec = v; sleeping = slp; wake_delay = WD_W'(wk);
        pc_in = pcv; instr_done = (!slp && d == 0);
        n = 0;
        while (n < 400) begin
            @(negedge clk);
            n++;
            if (pc_load && !got) begin
                got = 1; n_load = n; pco = pc_out; gie_at = gie;
            end
            if (got && !busy) break;
            sleeping   = 1'b0;
            instr_done = (!slp && d > 0 && n == d);
            // R8: request and return strobe while busy must be ignored
            irq_req    = (n == 1);
            reti_exec  = (n == 1);
            irq_vec    = (n == 1) ? ~v : v;
        end
        irq_req = 0; reti_exec = 0; instr_done = 0;
        check(n_load == entry_latency(slp, d, wk), slp ? "R7" : "R3", "entry latency",
              n_load, entry_latency(slp, d, wk));
        check(pco == VEC_BASE + 16'(v), "R2", "handler address", pco, VEC_BASE + 16'(v));
        check(gie_at == 1'b0, "R6", "gie at entry load", gie_at, 0);
        check(sp == sp0 - 8'd2, "R5", "sp after entry", sp, sp0 - 8'd2);
        check(stack_mem[sp0] == pcv[7:0], "R5", "low byte", stack_mem[sp0], pcv[7:0]);
        check(stack_mem[sp0 - 8'd1] == pcv[15:8], "R5", "high byte",
              stack_mem[sp0 - 8'd1], pcv[15:8]);
    endtask

    task automatic masked_request(input logic [VEC_W-1:0] v);
        logic [SP_W-1:0] sp0;
        bit seen;
        sp0 = sp; seen = 0;
        irq_req = 1'b1; irq_vec = v;
        @(negedge clk);
        irq_req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (busy || pc_load) seen = 1;
            @(negedge clk);
        end
        check(!seen && sp == sp0, "R8", "request with gie clear", seen, 0);
    endtask

    task automatic run_return(input logic [15:0] pcv);
        logic [SP_W-1:0] sp0;
        int n, n_load;
        bit got;
        logic [15:0] pco;
        sp0 = sp; n_load = -1; got = 0; pco = '0;
        reti_exec = 1'b1;
        n = 0;
        while (n < 50) begin
            @(negedge clk);
            n++;
            reti_exec = 1'b0;
            if (pc_load && !got) begin
                got = 1; n_load = n; pco = pc_out;
            end
            if (got && !busy) break;
        end
        check(n_load == 4, "R9", "return latency", n_load, 4);
        check(pco == pcv, "R9", "restored pc", pco, pcv);
        check(sp == sp0 + 8'd2, "R10", "sp after return", sp, sp0 + 8'd2);
        check(gie == 1'b1, "R10", "gie after return", gie, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int a = 0; a < (1 << SP_W); a++) stack_mem[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && gie && sp == SP_INIT && !mem_we && !mem_re && !pc_load,
              "R1", "reset state", {busy, gie, mem_we, mem_re, pc_load}, 5'b01000);

        // Directed corners: completion at acceptance, late completion, sleep wakes
        run_entry(5'd3, 0, 1'b0, 0, 16'h1234);
        masked_request(5'd7);
        run_return(16'h1234);
        run_entry(5'd9, 3, 1'b0, 0, 16'hBEEF);
        run_return(16'hBEEF);
        run_entry(5'd0, 0, 1'b1, 0, 16'h00FF);
        run_return(16'h00FF);
        run_entry(5'd31, 0, 1'b1, 5, 16'hFF00);
        masked_request(5'd1);
        run_return(16'hFF00);

        for (int it = 0; it < 24; it++) begin
            logic [VEC_W-1:0] v;
            logic [15:0] pcv;
            int d, wk;
            bit slp;
            v   = VEC_W'($urandom_range(0, (1 << VEC_W) - 1));
            pcv = 16'($urandom);
            d   = $urandom_range(0, 5);
            slp = ($urandom_range(0, 3) == 0);
            wk  = $urandom_range(0, 9);
            run_entry(v, d, slp, wk, pcv);
            run_return(pcv);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule